// File: doc/BRIEF.md
# Interrupt Cause and Enable Controller

This block gathers event pulses from the receive and transmit paths of a network controller and turns them into one level-sensitive interrupt line. Each event pulse latches into a sticky bit of a 32-bit cause register. A separate enable register selects which causes may raise the interrupt. Bit 31 of the cause register is a read-only summary that copies the interrupt line.

Software reaches the block through a simple single-cycle 32-bit bus, using four word-aligned registers:

- The status view of the causes. A read returns the causes and then clears them. A write of 1s clears the chosen causes.
- A force register. Writing 1s to it injects causes for testing.
- An enable-set register. Writing 1s to it enables sources, and a read returns the current enables.
- An enable-clear register. Writing 1s to it disables sources.

Only the event positions that exist are built as storage. Every other position reads as zero.

Bus reads are handled by a two-state machine. In `BUS_IDLE` no response is pending. A read request moves it to `BUS_RESP`, where the registered read data is presented with a valid strobe for one cycle. From `BUS_RESP` a further read request keeps it in `BUS_RESP`, which gives back-to-back reads. Any other cycle returns it to `BUS_IDLE`.

Top module: `irq_ctl`

## Requirements
- R1: After reset, all cause bits and all enable bits are zero, `irq_o` is low and `bus_rvalid` is low.
- R2: A write to the enable-set register at byte offset 0x00D0 sets each enable bit whose data bit is 1 and leaves every other enable bit unchanged. A read of offset 0x00D0 returns the current enables.
- R3: A write to the enable-clear register at byte offset 0x00D8 clears each enable bit whose data bit is 1 and leaves every other enable bit unchanged.
- R4: A write to the cause status register at byte offset 0x00C0 clears each cause bit whose data bit is 1 and leaves every other cause bit unchanged. Bit 31 cannot be altered by a write.
- R5: A write to the force register at byte offset 0x00C8 sets the chosen cause bits as if their events had occurred. The interrupt rises only when a matching enable bit is set.
- R6: `irq_o` is high exactly when some bit in positions 30..0 is set in both the cause and enable registers. Bit 31 of a cause status read shows the value `irq_o` had in the cycle of the read request.
- R7: A read of offset 0x00C0 returns the causes from before the read and clears all of them in the same cycle. An event pulse that arrives in the read cycle is kept.
- R8: An event pulse on `evt_i[k]` sets cause bit k. The implemented positions are:

  | Bit | Event |
  |-----|-------|
  | 0 | transmit descriptor written back |
  | 1 | transmit queue empty |
  | 2 | link status change |
  | 4 | receive descriptor minimum threshold |
  | 6 | receiver overrun |
  | 7 | receive timer expired |
  | 9 | management access complete |
  | 15 | transmit descriptor low threshold |
  | 16 | small receive packet |
  | 17 | receive acknowledge frame |

  The implemented-position mask is 0x000382D7.
- R9: Unimplemented cause and enable positions read as zero and ignore writes and events.
- R10: `bus_rvalid` is high in the cycle after each read request and low otherwise, and back-to-back reads each get a response. Reads of offsets 0x00C8 and 0x00D8, and reads of any unmapped offset, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 31 | Event pulses, one per cause position 30..0 |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; bits 1..0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| irq_o | output | 1 | Interrupt line, active high |

## Verification
On every cycle, the checker confirms the following behaviours:
- Enable and clear writes leave exactly the chosen enable bits set or cleared.
- The enables stay fixed when the enable registers are not addressed.
- Events latch into the cause register.
- A cause read leaves behind only the events that arrived with it.
- The read strobe follows each read request by one cycle.
- Unimplemented positions read as zero.
- The summary bit matches the line.

Some behaviours only the bench's sweeps show, because they depend on the history of several accesses:
- The interrupt rising only once a forced cause is also enabled.
- Write-1-to-clear leaving the other causes intact.
- The zero reads of the write-only offsets and unmapped offsets.
- The order of data in back-to-back reads.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned NUM_SRC  = 31;
    localparam int unsigned SUM_BIT  = 31;

    localparam logic [15:0] OFF_EVT_STAT  = 16'h00C0;
    localparam logic [15:0] OFF_EVT_FORCE = 16'h00C8;
    localparam logic [15:0] OFF_EN_SET    = 16'h00D0;
    localparam logic [15:0] OFF_EN_CLR    = 16'h00D8;

    // positions of the event sources that exist in this controller
    localparam logic [31:0] IMPL_DEFAULT  = 32'h0003_82D7;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

    typedef struct packed {
        logic stat_wr;
        logic stat_rd;
        logic force_wr;
        logic enset_wr;
        logic enclr_wr;
    } acc_t;

endpackage

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [REG_W-1:0]        stat_view,
    input  logic [REG_W-1:0]        en_view,
    output acc_t                    acc,
    output logic [REG_W-1:0]        rdata,
    output logic                    rvalid
);

    localparam int unsigned WA_W = ADDR_W - 2;

    logic [WA_W-1:0] word_addr;
    logic            hit_stat;
    logic            hit_force;
    logic            hit_enset;
    logic            hit_enclr;
    logic            rd_req;
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rdata_q;

    bus_state_t state_q;
    bus_state_t state_d;

    assign word_addr = addr[ADDR_W-1:2];
    assign hit_stat  = (word_addr == OFF_EVT_STAT[ADDR_W-1:2]);
    assign hit_force = (word_addr == OFF_EVT_FORCE[ADDR_W-1:2]);
    assign hit_enset = (word_addr == OFF_EN_SET[ADDR_W-1:2]);
    assign hit_enclr = (word_addr == OFF_EN_CLR[ADDR_W-1:2]);
    assign rd_req    = req & ~we;

    always_comb begin
        acc          = '0;
        acc.stat_wr  = req & we & hit_stat;
        acc.stat_rd  = rd_req & hit_stat;
        acc.force_wr = req & we & hit_force;
        acc.enset_wr = req & we & hit_enset;
        acc.enclr_wr = req & we & hit_enclr;
    end

    // write-only and unmapped offsets return zero
    always_comb begin
        rd_mux = '0;
        if (hit_stat) begin
            rd_mux = stat_view;
        end else if (hit_enset) begin
            rd_mux = en_view;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_mux;
        end
    end

    // outputs
    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            BUS_IDLE: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
            BUS_RESP: begin
                rvalid = 1'b1;
                rdata  = rdata_q;
            end
            default: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
    import irq_ctl_pkg::*;
#(
    parameter logic [31:0] IMPL = IMPL_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt,
    input  logic [REG_W-1:0] set_bits,
    input  logic [REG_W-1:0] clr_bits,
    input  logic             clr_all,
    output logic [REG_W-1:0] cause_q
);

    // the summary position never holds state
    localparam logic [31:0] IMPL_EFF = IMPL & 32'h7FFF_FFFF;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_EFF[i]) begin : g_flop
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cause_q[i] <= 1'b0;
                end else begin
                    // new events and injections win over any clear
                    cause_q[i] <= evt[i] | set_bits[i] |
                                  (cause_q[i] & ~clr_bits[i] & ~clr_all);
                end
            end
        end else begin : g_tie
            assign cause_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_ctl_pkg::*;
#(
    parameter logic [31:0] IMPL = IMPL_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_bits,
    input  logic [REG_W-1:0] clr_bits,
    output logic [REG_W-1:0] mask_q
);

    localparam logic [31:0] IMPL_EFF = IMPL & 32'h7FFF_FFFF;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_EFF[i]) begin : g_flop
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask_q[i] <= 1'b0;
                end else begin
                    mask_q[i] <= set_bits[i] | (mask_q[i] & ~clr_bits[i]);
                end
            end
        end else begin : g_tie
            assign mask_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter logic [31:0] CAUSE_IMPL = IMPL_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_o
);

    acc_t             acc;
    logic [REG_W-1:0] evt_full;
    logic [REG_W-1:0] cause_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] cause_set;
    logic [REG_W-1:0] cause_clr;
    logic [REG_W-1:0] mask_set;
    logic [REG_W-1:0] mask_clr;
    logic [REG_W-1:0] stat_view;

    assign evt_full  = {1'b0, evt_i};
    assign cause_set = acc.force_wr ? bus_wdata : '0;
    assign cause_clr = acc.stat_wr  ? bus_wdata : '0;
    assign mask_set  = acc.enset_wr ? bus_wdata : '0;
    assign mask_clr  = acc.enclr_wr ? bus_wdata : '0;

    assign irq_o     = |(cause_q[NUM_SRC-1:0] & mask_q[NUM_SRC-1:0]);
    assign stat_view = {irq_o, cause_q[NUM_SRC-1:0]};

    irq_bus_fsm #(
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .stat_view (stat_view),
        .en_view   (mask_q),
        .acc       (acc),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    irq_cause_reg #(
        .IMPL (CAUSE_IMPL)
    ) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_full),
        .set_bits (cause_set),
        .clr_bits (cause_clr),
        .clr_all  (acc.stat_rd),
        .cause_q  (cause_q)
    );

    irq_mask_reg #(
        .IMPL (CAUSE_IMPL)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (mask_set),
        .clr_bits (mask_clr),
        .mask_q   (mask_q)
    );

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
    import irq_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter logic [31:0] CAUSE_IMPL = IMPL_DEFAULT
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               bus_req,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [REG_W-1:0]   bus_rdata,
    input logic               bus_rvalid,
    input logic               irq_o,
    input logic [REG_W-1:0]   cause_q,
    input logic [REG_W-1:0]   mask_q
);

    localparam logic [31:0] IMPL_EFF = CAUSE_IMPL & 32'h7FFF_FFFF;

    logic rd_any;
    logic rd_stat;
    logic wr_set;
    logic wr_clr;
    logic [REG_W-1:0] evt_mask;

    assign rd_any   = bus_req & ~bus_we;
    assign rd_stat  = rd_any & (bus_addr[ADDR_W-1:2] == OFF_EVT_STAT[ADDR_W-1:2]);
    assign wr_set   = bus_req & bus_we & (bus_addr[ADDR_W-1:2] == OFF_EN_SET[ADDR_W-1:2]);
    assign wr_clr   = bus_req & bus_we & (bus_addr[ADDR_W-1:2] == OFF_EN_CLR[ADDR_W-1:2]);
    assign evt_mask = {1'b0, evt_i} & IMPL_EFF;

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_q & $past(bus_wdata & IMPL_EFF)) == $past(bus_wdata & IMPL_EFF)));

    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(mask_q));

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_q & $past(bus_wdata)) == '0));

    assert_sum_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (bus_rdata[31] == $past(irq_o)));

    assert_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (cause_q == $past(evt_mask)));

    assert_evt_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(evt_mask)) == $past(evt_mask)));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> ((bus_rdata & ~IMPL_EFF & 32'h7FFF_FFFF) == '0));

    assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> bus_rvalid);

    assert_no_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> !bus_rvalid);

endmodule

bind irq_ctl irq_ctl_chk #(
    .ADDR_W     (ADDR_W),
    .CAUSE_IMPL (CAUSE_IMPL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq_o      (irq_o),
    .cause_q    (cause_q),
    .mask_q     (mask_q)
);

// File: tb/irq_ctl_tb.sv
module irq_ctl_tb;

    localparam logic [31:0] IMPL   = 32'h0003_82D7;
    localparam logic [15:0] A_STAT = 16'h00C0;
    localparam logic [15:0] A_FRC  = 16'h00C8;
    localparam logic [15:0] A_ESET = 16'h00D0;
    localparam logic [15:0] A_ECLR = 16'h00D8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] evt = '0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mc = '0;
    logic [31:0] mm = '0;

    always #5 clk = ~clk;

    irq_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .bus_req    (req),
        .bus_we     (we),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .bus_rvalid (rvalid),
        .irq_o      (irq)
    );

    function automatic logic m_irq();
        return |(mc & mm & 32'h7FFF_FFFF);
    endfunction

    function automatic logic [31:0] m_stat();
        return (mc & 32'h7FFF_FFFF) | {m_irq(), 31'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
        check("R10 rvalid after read", {31'b0, rvalid}, 32'd1);
    endtask

    task automatic pulse(input logic [30:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 rvalid", {31'b0, rvalid}, 32'd0);
        do_read(A_STAT, d); check("R1 cause", d, 32'd0);
        do_read(A_ESET, d); check("R1 enable", d, 32'd0);

        // R2 / R9 enable set sweep
        for (int i = 0; i < 32; i++) begin
            b = 32'd1 << i;
            do_write(A_ESET, b);
            mm = mm | (b & IMPL);
            do_read(A_ESET, d); check("R2 R9 enable set", d, mm);
        end
        do_write(A_ESET, 32'd0);
        do_read(A_ESET, d); check("R2 zero write keeps", d, mm);

        // R3 enable clear sweep
        for (int i = 0; i < 32; i++) begin
            b = 32'd1 << i;
            do_write(A_ECLR, b);
            mm = mm & ~b;
            do_read(A_ESET, d); check("R3 enable clear", d, mm);
        end

        // R4 R5 R6 R7 per-bit sweep
        for (int i = 0; i < 32; i++) begin
            b = 32'd1 << i;
            do_write(A_FRC, b);
            mc = mc | (b & IMPL);
            check("R5 no irq when disabled", {31'b0, irq}, 32'd0);
            do_write(A_ESET, b);
            mm = mm | (b & IMPL);
            check("R6 irq level", {31'b0, irq}, {31'b0, m_irq()});
            do_write(A_STAT, b | 32'h8000_0000);
            mc = mc & ~b;
            check("R4 w1c drops irq", {31'b0, irq}, 32'd0);
            do_write(A_FRC, b);
            mc = mc | (b & IMPL);
            do_read(A_STAT, d); check("R7 R6 read status", d, m_stat());
            mc = '0;
            do_read(A_STAT, d); check("R7 cleared by read", d, 32'd0);
            do_write(A_ECLR, b);
            mm = mm & ~b;
        end

        // R4 selective clear keeps others
        do_write(A_FRC, 32'h0000_0015);
        mc = 32'h0000_0015 & IMPL;
        do_write(A_STAT, 32'h0000_0004);
        mc = mc & ~32'h4;
        do_read(A_STAT, d); check("R4 other causes kept", d, m_stat());
        mc = '0;

        // R8 event sweep with all enables on
        do_write(A_ESET, 32'hFFFF_FFFF);
        mm = IMPL;
        for (int i = 0; i < 31; i++) begin
            b = 32'd1 << i;
            pulse(b[30:0]);
            mc = b & IMPL;
            check("R8 irq from event", {31'b0, irq}, {31'b0, m_irq()});
            do_read(A_STAT, d); check("R8 event latched", d, m_stat());
            mc = '0;
        end

        // R7 event coincident with a clearing read
        do_write(A_FRC, 32'h0000_0003);
        mc = 32'h3;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = A_STAT; evt = 31'h10;
        @(negedge clk);
        req = 1'b0; evt = '0;
        check("R7 read old value", rdata, m_stat());
        mc = 32'h10;
        do_read(A_STAT, d); check("R7 coincident event kept", d, m_stat());
        mc = '0;

        // R9 force all ones
        do_write(A_FRC, 32'hFFFF_FFFF);
        mc = IMPL;
        do_read(A_STAT, d); check("R9 reserved read zero", d, m_stat());
        mc = '0;

        // R10 write-only and unmapped offsets
        do_read(A_FRC, d);    check("R10 force reads zero", d, 32'd0);
        do_read(A_ECLR, d);   check("R10 clear reads zero", d, 32'd0);
        do_read(16'h0100, d); check("R10 unmapped reads zero", d, 32'd0);
        @(negedge clk);
        check("R10 rvalid drops", {31'b0, rvalid}, 32'd0);

        // R10 back-to-back reads
        do_write(A_FRC, 32'h0000_0040);
        mc = 32'h40;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = A_ESET;
        @(negedge clk);
        addr = A_STAT;
        check("R10 first of pair", rdata, mm);
        check("R10 first valid", {31'b0, rvalid}, 32'd1);
        @(negedge clk);
        req = 1'b0;
        check("R10 second of pair", rdata, m_stat());
        check("R10 second valid", {31'b0, rvalid}, 32'd1);
        mc = '0;
        @(negedge clk);
        check("R10 pair ends", {31'b0, rvalid}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule